// File: doc/BRIEF.md
# Four-Level Prioritized Interrupt Controller

This block arbitrates fourteen interrupt request lines for a small 8-bit processor core. Each line is gated by its own enable bit and by one global enable. Each line carries a two-bit priority code made of a high bit and a low bit. The controller selects the strongest eligible request and registers it. It then offers that request to the core as a valid/ready transfer, together with the handler's 16-bit vector address and its priority code.

The core accepts a request with `irq_ack_i`. In the cycle after this handshake, the controller records the granted level in a four-bit in-service register. In the same cycle it issues a one-cycle clear strobe for flags that hardware clears on vectoring. When a handler ends, the core pulses `reti_i`, and this clears the highest level still in service. A new request reaches the core only when its level is strictly above every level now in service. This gives nesting by strictly higher levels only.

The stream rules are as follows. `irq_valid_o` is registered. Once it is raised, it stays high, and `irq_vec_o` and `irq_lvl_o` stay stable, until the cycle where `irq_ack_i` is sampled high. No new arbitration takes place while a request is waiting. Stronger requests that appear in the meantime are served after the handshake.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_valid_o`, `in_svc_o` and `flag_clr_o` are all zero.
- R2: While `glb_en_i` is low, no new request is presented (`irq_valid_o` stays low).
- R3: A source whose bit in `src_en_i` is low is ignored, whatever its request and priority.
- R4: A source's level code is {`prio_hi_i[i]`,`prio_lo_i[i]`}. 11 is the strongest level, then 10, then 01, and 00 is the weakest. Among eligible requests of different levels, the strongest level is presented.
- R5: Within one level, the lowest source index wins. The index order is 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial0, 5 timer2, 6 ext2, 7 ext3, 8 SPI, 9 ADC, 10 PCA counter, 11 brown-out, 12 serial1, 13 keypad.
- R6: `irq_vec_o` equals 16'h0003 + 8 × (index of the presented source), so it runs from 0003h to 006Bh.
- R7: While `irq_valid_o` is high and `irq_ack_i` is low, `irq_valid_o`, `irq_vec_o` and `irq_lvl_o` keep their values, even if a stronger request appears.
- R8: A request is presented only if its level code is strictly greater than every level code set in `in_svc_o`. Equal and weaker levels wait.
- R9: A handshake (`irq_valid_o` and `irq_ack_i` both high at a clock edge) drops `irq_valid_o` and sets bit `irq_lvl_o` of `in_svc_o` on the next cycle. Bit 3 corresponds to code 11.
- R10: A `reti_i` pulse clears the highest set bit of `in_svc_o`. If it coincides with a handshake, both the clear and the set take effect.
- R11: In the cycle after a handshake, `flag_clr_o` carries a single-cycle pulse on the granted source's bit, under these conditions:
  - Sources 1 and 3 always receive the pulse.
  - Sources 0, 2, 6 and 7 receive it only when `ext_edge_i` bit 0, 1, 2 or 3 (respectively) is high.
  - No other source ever receives it.
- R12: `irq_ack_i` while `irq_valid_o` is low has no effect on `in_svc_o` or `flag_clr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 14 | Raw request flags, one per source |
| src_en_i | input | 14 | Per-source enable |
| glb_en_i | input | 1 | Global enable |
| prio_hi_i | input | 14 | High bit of each source's level code |
| prio_lo_i | input | 14 | Low bit of each source's level code |
| ext_edge_i | input | 4 | Transition mode for ext0, ext1, ext2, ext3 |
| irq_ack_i | input | 1 | Core accepts the presented request (ready) |
| reti_i | input | 1 | Handler finished pulse |
| irq_valid_o | output | 1 | A request is presented (valid) |
| irq_vec_o | output | 16 | Vector address of the presented request |
| irq_lvl_o | output | 2 | Level code of the presented request |
| flag_clr_o | output | 14 | One-cycle hardware clear strobes |
| in_svc_o | output | 4 | In-service bit per level code |

## Verification
The bench goes after the following corner cases and the failures each one exposes.

- **Same-level request during a handler.** A request at the level already in service must wait. A design that compares with "greater or equal" would nest it at once.
- **Two consecutive returns.** The bench checks that each return strips only the top level. A design that clears the whole register would release the waiting same-level request one return too early.
- **Stronger request while one is pending.** A stronger request arriving while an earlier one is still pending must not change the vector. A design that re-arbitrates every cycle would break the handshake.
- **Clear strobes.** The bench checks that clear strobes appear only for timer0/timer1 and for edge-mode external sources. A design with a wrong source map would wipe serial-port or level-mode flags that software owns.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int SRC_EXT0   = 0;
  localparam int SRC_TMR0   = 1;
  localparam int SRC_EXT1   = 2;
  localparam int SRC_TMR1   = 3;
  localparam int SRC_EXT2   = 6;
  localparam int SRC_EXT3   = 7;

  // Whether vectoring to source idx should strobe its flag clear.
  function automatic logic hw_clears(input int idx, input logic [3:0] edge_mode);
    case (idx)
      SRC_TMR0, SRC_TMR1: return 1'b1;
      SRC_EXT0:           return edge_mode[0];
      SRC_EXT1:           return edge_mode[1];
      SRC_EXT2:           return edge_mode[2];
      SRC_EXT3:           return edge_mode[3];
      default:            return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_level_pick.sv
// Finds the lowest-index active source whose level code equals LVL.
module irq_level_pick #(
  parameter int NSRC = 14,
  parameter int LW   = 2,
  parameter int LVL  = 0,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]    act_i,
  input  logic [NSRC*LW-1:0] code_i,
  output logic               hit_o,
  output logic [IW-1:0]      idx_o
);

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act_i[i] && (code_i[i*LW +: LW] == LW'(LVL))) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_insvc_stack.sv
// One bit per level code; push sets a level, pop clears the strongest one.
module irq_insvc_stack #(
  parameter int NLVL = 4,
  localparam int LW  = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic [LW-1:0]   push_lvl_i,
  input  logic            pop_i,
  output logic [NLVL-1:0] svc_o,
  output logic            top_hit_o,
  output logic [LW-1:0]   top_lvl_o
);

  logic [NLVL-1:0] svc_q;
  logic [NLVL-1:0] top_mask;
  logic [NLVL-1:0] svc_d;

  always_comb begin
    top_hit_o = 1'b0;
    top_lvl_o = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (svc_q[l]) begin
        top_hit_o = 1'b1;
        top_lvl_o = LW'(l);
      end
    end
    top_mask = top_hit_o ? (NLVL'(1) << top_lvl_o) : '0;
    svc_d = pop_i ? (svc_q & ~top_mask) : svc_q;
    if (push_i) svc_d = svc_d | (NLVL'(1) << push_lvl_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  assign svc_o = svc_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int          NSRC     = 14,
  parameter int          NLVL     = 4,
  parameter int          NEXT     = 4,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter logic [15:0] VEC_STEP = 16'h0008,
  localparam int         LW       = $clog2(NLVL),
  localparam int         IW       = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] src_en_i,
  input  logic            glb_en_i,
  input  logic [NSRC-1:0] prio_hi_i,
  input  logic [NSRC-1:0] prio_lo_i,
  input  logic [NEXT-1:0] ext_edge_i,
  input  logic            irq_ack_i,
  input  logic            reti_i,
  output logic            irq_valid_o,
  output logic [15:0]     irq_vec_o,
  output logic [LW-1:0]   irq_lvl_o,
  output logic [NSRC-1:0] flag_clr_o,
  output logic [NLVL-1:0] in_svc_o
);

  import irq_pkg::*;

  logic [NSRC-1:0]    act;
  logic [NSRC*LW-1:0] code_flat;
  logic [NLVL-1:0]    lvl_hit;
  logic [IW-1:0]      lvl_idx [NLVL];

  logic               win_hit;
  logic [LW-1:0]      win_lvl;
  logic [IW-1:0]      win_idx;
  logic               top_hit;
  logic [LW-1:0]      top_lvl;
  logic               grant_ok;
  logic               hs;

  logic               valid_q;
  logic [IW-1:0]      src_q;
  logic [LW-1:0]      lvl_q;
  logic [15:0]        vec_q;
  logic [NSRC-1:0]    clr_q;

  assign act = req_i & src_en_i & {NSRC{glb_en_i}};

  genvar gs;
  generate
    for (gs = 0; gs < NSRC; gs++) begin : g_code
      assign code_flat[gs*LW +: LW] = LW'({prio_hi_i[gs], prio_lo_i[gs]});
    end
  endgenerate

  genvar gl;
  generate
    for (gl = 0; gl < NLVL; gl++) begin : g_lvl
      irq_level_pick #(.NSRC(NSRC), .LW(LW), .LVL(gl)) u_pick (
        .act_i  (act),
        .code_i (code_flat),
        .hit_o  (lvl_hit[gl]),
        .idx_o  (lvl_idx[gl])
      );
    end
  endgenerate

  // Strongest level with any hit wins; its picker already applied poll order.
  always_comb begin
    win_hit = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (lvl_hit[l]) begin
        win_hit = 1'b1;
        win_lvl = LW'(l);
        win_idx = lvl_idx[l];
      end
    end
  end

  irq_insvc_stack #(.NLVL(NLVL)) u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (hs),
    .push_lvl_i (lvl_q),
    .pop_i      (reti_i),
    .svc_o      (in_svc_o),
    .top_hit_o  (top_hit),
    .top_lvl_o  (top_lvl)
  );

  assign grant_ok = win_hit && (!top_hit || (win_lvl > top_lvl));
  assign hs       = valid_q & irq_ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      lvl_q   <= '0;
      vec_q   <= '0;
      clr_q   <= '0;
    end else begin
      clr_q <= '0;
      if (hs) begin
        valid_q <= 1'b0;
        for (int i = 0; i < NSRC; i++) begin
          if ((IW'(i) == src_q) && hw_clears(i, 4'(ext_edge_i))) clr_q[i] <= 1'b1;
        end
      end else if (!valid_q && grant_ok) begin
        valid_q <= 1'b1;
        src_q   <= win_idx;
        lvl_q   <= win_lvl;
        vec_q   <= VEC_BASE + VEC_STEP * {{(16-IW){1'b0}}, win_idx};
      end
    end
  end

  assign irq_valid_o = valid_q;
  assign irq_vec_o   = vec_q;
  assign irq_lvl_o   = lvl_q;
  assign flag_clr_o  = clr_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NSRC = 14,
  parameter int NLVL = 4,
  localparam int LW  = $clog2(NLVL)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req_i,
  input logic [NSRC-1:0] src_en_i,
  input logic            glb_en_i,
  input logic            irq_ack_i,
  input logic            reti_i,
  input logic            irq_valid_o,
  input logic [15:0]     irq_vec_o,
  input logic [LW-1:0]   irq_lvl_o,
  input logic [NSRC-1:0] flag_clr_o,
  input logic [NLVL-1:0] in_svc_o
);

  p_gate_global_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en_i && !irq_valid_o) |=> !irq_valid_o);

  p_enabled_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid_o) |-> $past(|(req_i & src_en_i)));

  p_vec_form_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_vec_o[2:0] == 3'b011) && (irq_vec_o <= 16'h006B));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !irq_ack_i) |=> irq_valid_o && $stable(irq_vec_o) && $stable(irq_lvl_o));

  p_strict_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid_o) |-> (($past(in_svc_o) >> irq_lvl_o) == '0));

  p_ack_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ack_i) |=> !irq_valid_o && in_svc_o[$past(irq_lvl_o)]);

  p_reti_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !irq_ack_i && in_svc_o != '0) |=>
      ($countones(in_svc_o) + 1 == $countones($past(in_svc_o))));

  p_clr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_o != '0) |-> $past(irq_valid_o && irq_ack_i) && $onehot0(flag_clr_o));

  p_idle_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid_o && irq_ack_i && !reti_i) |=> $stable(in_svc_o) && (flag_clr_o == '0));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .NLVL(NLVL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .src_en_i    (src_en_i),
  .glb_en_i    (glb_en_i),
  .irq_ack_i   (irq_ack_i),
  .reti_i      (reti_i),
  .irq_valid_o (irq_valid_o),
  .irq_vec_o   (irq_vec_o),
  .irq_lvl_o   (irq_lvl_o),
  .flag_clr_o  (flag_clr_o),
  .in_svc_o    (in_svc_o)
);

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] req, en, hi, lo, clr;
  logic        glb, ack, reti, valid;
  logic [3:0]  edge_m, svc;
  logic [15:0] vec;
  logic [1:0]  lvl;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .src_en_i(en), .glb_en_i(glb),
    .prio_hi_i(hi), .prio_lo_i(lo), .ext_edge_i(edge_m), .irq_ack_i(ack),
    .reti_i(reti), .irq_valid_o(valid), .irq_vec_o(vec), .irq_lvl_o(lvl),
    .flag_clr_o(clr), .in_svc_o(svc)
  );

  // {req, en, glb, hi, lo, exp_valid, exp_vec}
  localparam int NV = 8;
  localparam logic [73:0] TBL [NV] = '{
    {14'h0001, 14'h3FFF, 1'b1, 14'h0000, 14'h0000, 1'b1, 16'h0003},
    {14'h3FFF, 14'h3FFF, 1'b0, 14'h0000, 14'h0000, 1'b0, 16'h0000},
    {14'h2001, 14'h3FFF, 1'b1, 14'h2000, 14'h2000, 1'b1, 16'h006B},
    {14'h0220, 14'h3FFF, 1'b1, 14'h0000, 14'h0000, 1'b1, 16'h002B},
    {14'h1010, 14'h3FEF, 1'b1, 14'h0000, 14'h0000, 1'b1, 16'h0063},
    {14'h3FFF, 14'h0000, 1'b1, 14'h3FFF, 14'h3FFF, 1'b0, 16'h0000},
    {14'h0104, 14'h3FFF, 1'b1, 14'h0100, 14'h0004, 1'b1, 16'h0043},
    {14'h0C08, 14'h3FFF, 1'b1, 14'h0C00, 14'h0008, 1'b1, 16'h0053}
  };
  localparam string TAGS [NV] = '{"R6", "R2", "R4", "R5", "R3", "R3", "R4", "R5"};

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; en = '0; hi = '0; lo = '0; glb = 1'b0;
    ack = 1'b0; reti = 1'b0; edge_m = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    #4ms;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk(!valid && svc == 0 && clr == 0, "R1", {valid, svc, clr}, 0);

    for (int k = 0; k < NV; k++) begin
      do_reset();
      req = TBL[k][73:60]; en = TBL[k][59:46]; glb = TBL[k][45];
      hi = TBL[k][44:31];  lo = TBL[k][30:17];
      step(); step();
      chk(valid == TBL[k][16], TAGS[k], valid, TBL[k][16]);
      if (TBL[k][16]) chk(vec == TBL[k][15:0], "R6", vec, TBL[k][15:0]);
    end

    // Directed: idle ack, hold, handshake, preemption by stronger level
    do_reset();
    ack = 1'b1; step(); ack = 1'b0;
    chk(svc == 0 && clr == 0, "R12", {svc, clr}, 0);
    en = 14'h3FFF; glb = 1'b1; req = 14'h0020;
    step();
    chk(valid && vec == 16'h002B, "R7", vec, 16'h002B);
    req = 14'h0021; hi = 14'h0001; lo = 14'h0001;
    step(); step();
    chk(valid && vec == 16'h002B && lvl == 2'b00, "R7", vec, 16'h002B);
    ack = 1'b1; step();
    chk(!valid && svc == 4'b0001, "R9", {valid, svc}, 4'b0001);
    chk(clr == 0, "R11", clr, 0);
    ack = 1'b0; req = 14'h0001;
    step();
    chk(valid && vec == 16'h0003 && lvl == 2'b11, "R8", vec, 16'h0003);
    ack = 1'b1; step();
    chk(svc == 4'b1001, "R9", svc, 4'b1001);
    chk(clr == 0, "R11", clr, 0);
    ack = 1'b0; req = '0; reti = 1'b1; step(); reti = 1'b0;
    chk(svc == 4'b0001, "R10", svc, 4'b0001);

    // Directed: nesting by strictly stronger levels only
    do_reset();
    en = 14'h3FFF; glb = 1'b1; edge_m = 4'b1000;
    lo = 14'h0012; hi = 14'h0080;
    req = 14'h0002; step();
    chk(valid && vec == 16'h000B, "R6", vec, 16'h000B);
    ack = 1'b1; step();
    chk(clr == 14'h0002 && svc == 4'b0010, "R11", {clr, svc}, {14'h0002, 4'b0010});
    ack = 1'b0; req = '0; step();
    chk(clr == 0, "R11", clr, 0);
    req = 14'h0050; step(); step();
    chk(!valid, "R8", valid, 0);
    req = 14'h00D0; step();
    chk(valid && vec == 16'h003B, "R8", vec, 16'h003B);
    ack = 1'b1; step();
    chk(clr == 14'h0080 && svc == 4'b0110, "R11", {clr, svc}, {14'h0080, 4'b0110});
    ack = 1'b0; req = 14'h0050; step();
    chk(!valid, "R8", valid, 0);
    reti = 1'b1; step(); reti = 1'b0;
    chk(svc == 4'b0010, "R10", svc, 4'b0010);
    step();
    chk(!valid, "R8", valid, 0);
    reti = 1'b1; step(); reti = 1'b0;
    chk(svc == 4'b0000, "R10", svc, 0);
    step();
    chk(valid && vec == 16'h0023, "R4", vec, 16'h0023);
    ack = 1'b1; reti = 1'b1; step();
    ack = 1'b0; reti = 1'b0;
    chk(svc == 4'b0010 && clr == 0, "R10", {svc, clr}, {4'b0010, 14'h0000});

    // Level-mode external source gets no clear strobe
    do_reset();
    en = 14'h3FFF; glb = 1'b1; edge_m = 4'b1110; req = 14'h0001;
    step(); ack = 1'b1; step(); ack = 1'b0; req = '0;
    chk(clr == 0 && svc == 4'b0001, "R11", clr, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule